// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block is the processor-side controller that takes over when the interrupt arbiter has accepted a request. The interrupt is sampled at instruction decode. When the sequencer is idle and a request is pending in the same cycle that an instruction decodes, that instruction is squashed and the entry sequence begins. The squashed instruction's address is kept as the return address, so the instruction runs again after the handler returns.

The sequence always runs in the same order, over a single-port memory interface with a ready handshake:

1. It reads the handler address from a vector table. The entry address is a base plus four times the vector number.
2. It pushes the saved status word onto a downward-growing stack.
3. It reports the status word with its 4-bit level mask replaced by the accepted level.
4. It pushes the return address.
5. It issues a plain jump with no delay slot. In the same cycle it tells the arbiter that entry is complete.

No new interrupt is taken until the sequence ends.

Top module: `irq_entry_seq`

## Requirements
- R1: In a cycle where `busy` is low and both `dec_valid` and `irq_req` are high, `squash` is high in that same cycle and an entry sequence starts. With only one of the two high, `squash` stays low and no memory request is raised.
- R2: In the cycle after a squash, `mem_req`=1, `mem_we`=0 and `mem_addr` = `VEC_BASE` + 4 × `irq_vec`. The word read when that access completes later appears on `pc_target`.
- R3: Once the vector read completes, the next access is a write of the `sr_in` value captured at the squash. Its address is `sp_out`−4, and `sp_out` takes that same value.
- R4: Once the status push completes, the next access is a write of the captured `dec_pc` at 4 below the new `sp_out`. `sp_out` again follows the address. After a sequence, `sp_out` is 8 below its starting value.
- R5: One cycle after the status push completes, `sr_wr_en` pulses for exactly one cycle. In that cycle `sr_wr_data` equals the captured status word with bits [MASK_LSB+3:MASK_LSB] replaced by the captured `irq_level`, and all other bits unchanged. This happens while the return-address push is still pending.
- R6: One cycle after the return-address push completes, `pc_load` and `irq_ack` pulse together for one cycle. In that cycle `pc_target` holds the vector word and `mem_req` is low.
- R7: An access completes on a clock edge where both `mem_req` and `mem_rdy` are high. While `mem_rdy` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R8: While `busy` is high, `squash` stays low whatever the inputs do, and exactly one vector read is made for each entry.
- R9: After reset, `mem_req`, `sr_wr_en`, `pc_load`, `irq_ack` and `busy` are low, and `sp_out` equals `SP_RESET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Accepted interrupt pending from the arbiter |
| irq_level | input | 4 | Priority level of the accepted interrupt |
| irq_vec | input | VEC_W | Vector number of the accepted interrupt |
| dec_valid | input | 1 | An instruction is being decoded this cycle |
| dec_pc | input | AW | Address of the instruction being decoded |
| sr_in | input | DW | Current status word |
| squash | output | 1 | Decoded instruction is dropped in favour of entry |
| busy | output | 1 | Entry sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access byte address |
| mem_wdata | output | DW | Write data |
| mem_rdy | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | DW | Read data, valid with `mem_rdy` |
| sp_out | output | AW | Stack pointer |
| sr_wr_en | output | 1 | Status word update strobe |
| sr_wr_data | output | DW | Status word with the new level mask |
| pc_load | output | 1 | Jump strobe |
| pc_target | output | AW | Handler start address |
| irq_ack | output | 1 | Entry complete, to the arbiter |

## Verification
The bench builds the block with a 6-bit vector number, so vector 63 is reachable and checks the top of the table. It uses a non-zero table base of 0x400, so a dropped base term shows up in the address. The stack starts at 0x2000, so both pushes land at addresses that are easy to tell apart. The memory's ready line alternates between always-ready and a pseudo-random pattern, which stretches every access phase and lets stalls land between the pushes.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VEC  = 2'd1,
    ST_SR   = 2'd2,
    ST_PC   = 2'd3
  } seq_st_t;
endpackage

// File: rtl/irq_seq_stack.sv
module irq_seq_stack #(
  parameter int AW = 32,
  parameter int STEP_BYTES = 4,
  parameter logic [AW-1:0] SP_RESET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] STEP = AW'(STEP_BYTES);

  always_ff @(posedge clk) begin
    if (rst)      sp <= SP_RESET;
    else if (dec) sp <= sp - STEP;
  end
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int VEC_W = 8,
  parameter int LW = 4,
  parameter int MASK_LSB = 4,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_req,
  input  logic [LW-1:0]    irq_level,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             dec_valid,
  input  logic [AW-1:0]    dec_pc,
  input  logic [DW-1:0]    sr_in,
  input  logic             mem_rdy,
  input  logic [DW-1:0]    mem_rdata,
  input  logic [AW-1:0]    sp,
  output logic             sp_dec,
  output logic             squash,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             sr_wr_en,
  output logic [DW-1:0]    sr_wr_data,
  output logic             pc_load,
  output logic [AW-1:0]    pc_target,
  output logic             irq_ack
);
  localparam int STEP_BYTES = DW / 8;
  localparam logic [AW-1:0] STEP = AW'(STEP_BYTES);
  localparam logic [DW-1:0] LVL_ONES = {{(DW-LW){1'b0}}, {LW{1'b1}}};
  localparam logic [DW-1:0] MASK_FIELD = LVL_ONES << MASK_LSB;

  seq_st_t st;
  logic [LW-1:0] lvl_q;
  logic [DW-1:0] sr_q;
  logic [AW-1:0] pc_q;
  logic          done;
  logic          take;

  assign done   = mem_req & mem_rdy;
  assign take   = (st == ST_IDLE) & dec_valid & irq_req;
  assign squash = take;
  assign busy   = (st != ST_IDLE);
  assign sp_dec = done & ((st == ST_VEC) | (st == ST_SR));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      lvl_q      <= '0;
      sr_q       <= '0;
      pc_q       <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      sr_wr_en   <= 1'b0;
      sr_wr_data <= '0;
      pc_load    <= 1'b0;
      pc_target  <= '0;
      irq_ack    <= 1'b0;
    end else begin
      sr_wr_en <= 1'b0;
      pc_load  <= 1'b0;
      irq_ack  <= 1'b0;
      case (st)
        ST_IDLE: if (take) begin
          lvl_q    <= irq_level;
          sr_q     <= sr_in;
          pc_q     <= dec_pc;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= VEC_BASE + AW'(irq_vec) * STEP;
          st       <= ST_VEC;
        end
        ST_VEC: if (done) begin
          pc_target <= AW'(mem_rdata);
          mem_we    <= 1'b1;
          mem_addr  <= sp - STEP;
          mem_wdata <= sr_q;
          st        <= ST_SR;
        end
        ST_SR: if (done) begin
          sr_wr_en   <= 1'b1;
          sr_wr_data <= (sr_q & ~MASK_FIELD) | (DW'(lvl_q) << MASK_LSB);
          mem_addr   <= sp - STEP;
          mem_wdata  <= DW'(pc_q);
          st         <= ST_PC;
        end
        ST_PC: if (done) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          pc_load <= 1'b1;
          irq_ack <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int VEC_W = 8,
  parameter int MASK_LSB = 4,
  parameter logic [AW-1:0] VEC_BASE = '0,
  parameter logic [AW-1:0] SP_RESET = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_req,
  input  logic [3:0]       irq_level,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             dec_valid,
  input  logic [AW-1:0]    dec_pc,
  input  logic [DW-1:0]    sr_in,
  output logic             squash,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_rdy,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    sp_out,
  output logic             sr_wr_en,
  output logic [DW-1:0]    sr_wr_data,
  output logic             pc_load,
  output logic [AW-1:0]    pc_target,
  output logic             irq_ack
);
  localparam int STEP_BYTES = DW / 8;
  logic sp_dec;

  irq_seq_stack #(
    .AW(AW), .STEP_BYTES(STEP_BYTES), .SP_RESET(SP_RESET)
  ) u_stack (
    .clk(clk), .rst(rst), .dec(sp_dec), .sp(sp_out)
  );

  irq_seq_ctrl #(
    .AW(AW), .DW(DW), .VEC_W(VEC_W), .LW(4),
    .MASK_LSB(MASK_LSB), .VEC_BASE(VEC_BASE)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vec(irq_vec),
    .dec_valid(dec_valid), .dec_pc(dec_pc), .sr_in(sr_in),
    .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .sp(sp_out), .sp_dec(sp_dec),
    .squash(squash), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .pc_load(pc_load), .pc_target(pc_target), .irq_ack(irq_ack)
  );
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int VEC_W = 8,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input logic             clk,
  input logic             rst,
  input logic [VEC_W-1:0] irq_vec,
  input logic             squash,
  input logic             busy,
  input logic             mem_req,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic             mem_rdy,
  input logic [AW-1:0]    sp_out,
  input logic             sr_wr_en,
  input logic             pc_load,
  input logic             irq_ack
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  a_r2_vec_addr: assert property (@(posedge clk) disable iff (rst)
    squash |=> (mem_req && !mem_we && mem_addr == VEC_BASE + AW'($past(irq_vec)) * STEP));

  a_r3_push_at_sp: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr == sp_out));

  a_r5_mask_before_pc: assert property (@(posedge clk) disable iff (rst)
    sr_wr_en |-> (mem_req && mem_we));

  a_r6_jump_pulse: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (irq_ack && !mem_req) ##1 !pc_load);

  a_r7_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r8_no_reentry: assert property (@(posedge clk) disable iff (rst)
    busy |-> !squash);
endmodule

bind irq_entry_seq irq_seq_chk #(
  .AW(AW), .DW(DW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst(rst), .irq_vec(irq_vec), .squash(squash), .busy(busy),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rdy(mem_rdy), .sp_out(sp_out), .sr_wr_en(sr_wr_en),
  .pc_load(pc_load), .irq_ack(irq_ack)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int VW = 6;
  localparam logic [31:0] VB  = 32'h0000_0400;
  localparam logic [31:0] SPR = 32'h0000_2000;
  localparam logic [31:0] RKEY = 32'h5A00_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic irq_req = 0, dec_valid = 0, mem_rdy = 0;
  logic [3:0] irq_level = 0;
  logic [VW-1:0] irq_vec = 0;
  logic [31:0] dec_pc = 0, sr_in = 0, mem_rdata;
  logic squash, busy, mem_req, mem_we, sr_wr_en, pc_load, irq_ack;
  logic [31:0] mem_addr, mem_wdata, sp_out, sr_wr_data, pc_target;

  int checks = 0, errors = 0;
  int fast = 1, vec_reads = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] bmem [logic [31:0]];

  // reference model state
  int ph = 0;
  logic [3:0]  m_lvl;
  logic [31:0] m_sr, m_pc, m_tgt;
  logic e_req = 0, e_we = 0, e_srw = 0, e_load = 0;
  logic [31:0] e_addr = 0, e_wd = 0, e_sp = SPR, e_srd = 0, e_tgt = 0;

  always #10 clk = ~clk;
  assign mem_rdata = mem_addr ^ RKEY;

  irq_entry_seq #(.AW(AW), .DW(DW), .VEC_W(VW), .MASK_LSB(4), .VEC_BASE(VB), .SP_RESET(SPR)) u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_level(irq_level), .irq_vec(irq_vec),
    .dec_valid(dec_valid), .dec_pc(dec_pc), .sr_in(sr_in), .squash(squash), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .sp_out(sp_out), .sr_wr_en(sr_wr_en),
    .sr_wr_data(sr_wr_data), .pc_load(pc_load), .pc_target(pc_target), .irq_ack(irq_ack));

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // behavioural reference and memory, updated on the rising edge
  always @(posedge clk) begin
    if (mem_req && mem_rdy && mem_we) bmem[mem_addr] = mem_wdata;
    if (mem_req && mem_rdy && !mem_we) vec_reads++;
    e_srw = 0; e_load = 0;
    if (rst) begin
      ph = 0; e_req = 0; e_we = 0; e_addr = 0; e_wd = 0; e_sp = SPR; e_srd = 0; e_tgt = 0;
    end else if (ph == 0) begin
      if (dec_valid && irq_req) begin
        m_lvl = irq_level; m_sr = sr_in; m_pc = dec_pc;
        e_req = 1; e_we = 0; e_addr = VB + 32'(irq_vec) * 4; ph = 1;
      end
    end else if (mem_rdy) begin
      if (ph == 1) begin
        m_tgt = mem_rdata; e_sp = e_sp - 4;
        e_we = 1; e_addr = e_sp; e_wd = m_sr; ph = 2;
      end else if (ph == 2) begin
        e_srw = 1; e_srd = {m_sr[31:8], m_lvl, m_sr[3:0]};
        e_sp = e_sp - 4; e_addr = e_sp; e_wd = m_pc; ph = 3;
      end else begin
        e_req = 0; e_we = 0; e_load = 1; e_tgt = m_tgt; ph = 0;
      end
    end
  end

  // per-cycle comparison away from the edge, then ready pattern and squash
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7", "mem_req", 32'(mem_req), 32'(e_req));
      if (e_req) begin
        chk("R3", "mem_we", 32'(mem_we), 32'(e_we));
        chk("R2", "mem_addr", mem_addr, e_addr);
        if (e_we) chk("R4", "mem_wdata", mem_wdata, e_wd);
      end
      chk("R4", "sp_out", sp_out, e_sp);
      chk("R5", "sr_wr_en", 32'(sr_wr_en), 32'(e_srw));
      if (e_srw) chk("R5", "sr_wr_data", sr_wr_data, e_srd);
      chk("R6", "pc_load", 32'(pc_load), 32'(e_load));
      chk("R6", "irq_ack", 32'(irq_ack), 32'(e_load));
      if (e_load) chk("R6", "pc_target", pc_target, e_tgt);
      chk("R8", "busy", 32'(busy), 32'(ph != 0));
    end
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rdy = (fast != 0) ? 1'b1 : lfsr[0];
    #3;
    if (!rst) chk("R1", "squash", 32'(squash), 32'(ph == 0 && dec_valid && irq_req));
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #2; end
  endtask

  task automatic run_irq(input logic [VW-1:0] v, input logic [3:0] lv, input logic [31:0] sr,
                         input logic [31:0] pc, input int hold);
    logic [31:0] sp0;
    int n;
    sp0 = sp_out;
    vec_reads = 0;
    irq_vec = v; irq_level = lv; sr_in = sr; dec_pc = pc; irq_req = 1; dec_valid = 1;
    cyc(1);
    if (hold == 0) begin irq_req = 0; dec_valid = 0; sr_in = ~sr; dec_pc = ~pc; irq_vec = ~v; end
    n = 0;
    while (!pc_load && n < 500) begin cyc(1); n++; end
    irq_req = 0; dec_valid = 0;
    chk("R6", "jump seen", 32'(pc_load), 32'd1);
    chk("R6", "target value", pc_target, (VB + 32'(v) * 4) ^ RKEY);
    chk("R3", "stacked status", bmem.exists(sp0 - 4) ? bmem[sp0 - 4] : 32'hDEAD_DEAD, sr);
    chk("R4", "stacked pc", bmem.exists(sp0 - 8) ? bmem[sp0 - 8] : 32'hDEAD_DEAD, pc);
    chk("R4", "sp net move", sp_out, sp0 - 8);
    chk("R8", "one vector read", 32'(vec_reads), 32'd1);
    cyc(2);
  endtask

  initial begin
    cyc(3);
    chk("R9", "reset mem_req", 32'(mem_req), 0);
    chk("R9", "reset sp", sp_out, SPR);
    chk("R9", "reset busy", 32'(busy), 0);
    chk("R9", "reset pc_load", 32'(pc_load), 0);
    chk("R9", "reset sr_wr_en", 32'(sr_wr_en), 0);
    rst = 0;
    cyc(2);
    // R1: either condition alone starts nothing
    dec_valid = 1; cyc(4);
    chk("R1", "decode alone", 32'(mem_req), 0);
    dec_valid = 0; irq_req = 1; cyc(4);
    chk("R1", "request alone", 32'(mem_req), 0);
    irq_req = 0; cyc(1);
    run_irq(6'd5, 4'd3, 32'h0000_00F1, 32'h0000_1234, 0);
    fast = 0;
    run_irq(6'd17, 4'd9, 32'hC3C3_0A5A, 32'h8000_0100, 1);
    run_irq(6'd63, 4'd15, 32'hFFFF_FF0F, 32'h0000_FFFC, 1);
    run_irq(6'd0, 4'd0, 32'hFFFF_FFFF, 32'h0000_0002, 0);
    fast = 1;
    run_irq(6'd42, 4'd7, 32'h1234_5678, 32'hABCD_EF00, 0);
    cyc(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule